// File: doc/BRIEF.md
# Status-Coded I2C Master Engine

This block is a byte-level I2C master for a processor-driven system. Software steers it through a small control word (start request, stop request, acknowledge enable, interrupt-flag clear, bit-rate select) and a data register. A read-only status byte reports the result of each bus step. After every step the engine loads a status code, raises an interrupt flag and holds the bus with SCL low. It does nothing more until software clears the flag. The control bits written in that same write then decide whether the engine issues a START, a STOP or the next byte.

The engine generates START, repeated START and STOP conditions, shifts address and data bytes MSB first, and handles the ninth (acknowledge) bit in both directions. It reports a misplaced START or STOP inside a byte as a bus error. It reports a released '1' that reads back as '0' as lost arbitration. SCL and SDA are open-drain: each has an output enable that pulls the line low and a separate input, and both inputs pass through two flip-flops before use.

Top module: `i2c_status_master`

## Requirements
- R1: After reset the status output reads F8h with the flag `si` low and both output enables low. Status bits [2:0] always read 0. The flag is never high while the status is F8h.
- R2: A control write with start=1 and flag-clear (`ctl_si`=0) while the bus is free first produces an SDA fall while SCL is high, then SCL low. It then posts code 08h with `si`=1.
- R3: While `si` is high, the status code and both output enables hold still, for any length of time.
- R4: The first byte after a START goes out MSB first, and SDA changes only while SCL is low. Address bit 0 is the direction (0 = write, 1 = read). With an ACK the code is 18h for a write address and 40h for a read address. With a NACK it is 20h for write and 48h for read.
- R5: A transmitted data byte posts 28h when the slave returns ACK and 30h when it returns NACK.
- R6: In read mode the master releases SDA for eight bits and shifts them into `dat_rdata`. On the ninth bit it drives ACK (SDA low) if the latched acknowledge bit is 1, and NACK otherwise. It then posts 50h or 58h accordingly.
- R7: A start request while the bus is already owned produces a repeated START and posts 10h.
- R8: A stop request produces an SDA rise while SCL is high and leaves both lines released. Status then returns to F8h with `si` staying low.
- R9: A START or STOP seen on the bus during an address, data or acknowledge bit posts 00h with `si`=1 and releases both lines at once.
- R10: A transmitted '1' that reads back as '0' posts 38h with `si`=1 and both lines released.
- R11: The rate field sets the SCL period in clock cycles: 0→256, 1→224, 2→192, 3→160, 4→960, 5→120, 6→60, and 7→60 (reserved, same as 6).
- R12: Stop has priority over start when both are requested. Data and control writes made while a bus step is running have no effect.
- R13: A data write in the same cycle as the control write that clears the flag supplies the byte that is transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_sta | input | 1 | Request START / repeated START |
| ctl_sto | input | 1 | Request STOP |
| ctl_aa | input | 1 | Acknowledge enable for received bytes |
| ctl_si | input | 1 | Flag value written; 0 clears the flag and launches the next step |
| ctl_rate | input | 3 | SCL bit-rate select |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Data register (received or last shifted byte) |
| status | output | 8 | Status code in bits [7:3], zeros in [2:0] |
| si | output | 1 | Interrupt flag: a new status is pending |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
Two things can land in the same cycle: the data-register write and the flag-clearing control write that launches a byte. The bench issues both in one cycle and checks that the slave model receives the newly written byte (R13). Two more coincidences are provoked on purpose. A start request and a stop request are given together, and the bench judges that only a STOP reaches the bus. Data and control writes are issued in the middle of a running byte, and the bench judges that the byte on the wire and the posted code are unchanged.

// File: rtl/i2c_status_master.sv
module i2c_status_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       ctl_sta,
  input  logic       ctl_sto,
  input  logic       ctl_aa,
  input  logic       ctl_si,
  input  logic [2:0] ctl_rate,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  output logic [7:0] status,
  output logic       si,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);

  localparam logic [4:0] C_IDLE = 5'h1F, C_BERR = 5'h00, C_START = 5'h01, C_RSTART = 5'h02,
                         C_AW_ACK = 5'h03, C_AW_NAK = 5'h04, C_DT_ACK = 5'h05, C_DT_NAK = 5'h06,
                         C_ARB = 5'h07, C_AR_ACK = 5'h08, C_AR_NAK = 5'h09,
                         C_DR_ACK = 5'h0A, C_DR_NAK = 5'h0B;

  typedef enum logic [1:0] {S_WAIT, S_START, S_STOP, S_BYTE} st_t;

  st_t        st;
  logic [1:0] step;
  logic [3:0] bitn;
  logic [7:0] qcnt, shreg;
  logic [4:0] code;
  logic [2:0] rate;
  logic       aa_q, active, addr_ph, rx_mode, rep;
  logic [1:0] scl_sy, sda_sy;
  logic       sda_d;

  function automatic logic [7:0] quarter(input logic [2:0] r);
    case (r)
      3'd0:    return 8'd64;
      3'd1:    return 8'd56;
      3'd2:    return 8'd48;
      3'd3:    return 8'd40;
      3'd4:    return 8'd240;
      3'd5:    return 8'd30;
      default: return 8'd15;
    endcase
  endfunction

  logic [7:0] qtr;
  logic       tick, scl_s, sda_s, start_det, stop_det, launch, drive;

  assign qtr       = quarter(rate);
  assign tick      = (st != S_WAIT) && (qcnt == 8'd0);
  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s & sda_d & ~sda_s;
  assign stop_det  = scl_s & ~sda_d & sda_s;
  assign launch    = ctl_wr & ~ctl_si & (st == S_WAIT);
  assign drive     = (bitn < 4'd8) ? (~rx_mode & ~shreg[7]) : (rx_mode & aa_q);
  assign status    = {code, 3'b000};
  assign dat_rdata = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT; step <= '0; bitn <= '0; qcnt <= '0; shreg <= '0;
      code <= C_IDLE; rate <= '0; aa_q <= 1'b0; active <= 1'b0;
      addr_ph <= 1'b0; rx_mode <= 1'b0; rep <= 1'b0; si <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      scl_sy <= 2'b11; sda_sy <= 2'b11; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      sda_d  <= sda_s;
      if (tick) qcnt <= qtr - 8'd1;
      else if (st != S_WAIT) qcnt <= qcnt - 8'd1;

      case (st)
        S_WAIT: begin
          if (ctl_wr) begin
            aa_q <= ctl_aa;
            rate <= ctl_rate;
          end
          if (dat_wr) shreg <= dat_wdata;
          if (launch) begin
            si   <= 1'b0;
            step <= '0;
            bitn <= '0;
            qcnt <= quarter(ctl_rate) - 8'd1;
            if (ctl_sto) begin
              if (active) st <= S_STOP;
              else        code <= C_IDLE;
            end else if (ctl_sta) begin
              st  <= S_START;
              rep <= active;
            end else if (active) begin
              st <= S_BYTE;
            end
          end
        end

        S_START: if (tick) begin
          step <= step + 2'd1;
          case (step)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe  <= 1'b1;
              st      <= S_WAIT;
              active  <= 1'b1;
              addr_ph <= 1'b1;
              rx_mode <= 1'b0;
              code    <= rep ? C_RSTART : C_START;
              si      <= 1'b1;
            end
          endcase
        end

        S_STOP: if (tick) begin
          step <= step + 2'd1;
          case (step)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              st     <= S_WAIT;
              active <= 1'b0;
              code   <= C_IDLE;
            end
          endcase
        end

        default: begin
          if (start_det || stop_det) begin
            code <= C_BERR; si <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0;
            active <= 1'b0; st <= S_WAIT;
          end else if (tick) begin
            step <= step + 2'd1;
            case (step)
              2'd0: sda_oe <= drive;
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                scl_oe <= 1'b1;
                bitn   <= bitn + 4'd1;
                if (bitn < 4'd8) begin
                  shreg <= {shreg[6:0], sda_s};
                  if (!rx_mode && !sda_oe && !sda_s) begin
                    code <= C_ARB; si <= 1'b1; scl_oe <= 1'b0; sda_oe <= 1'b0;
                    active <= 1'b0; st <= S_WAIT;
                  end
                end else begin
                  st      <= S_WAIT;
                  si      <= 1'b1;
                  addr_ph <= 1'b0;
                  if (addr_ph) begin
                    rx_mode <= shreg[0];
                    if (shreg[0]) code <= sda_s ? C_AR_NAK : C_AR_ACK;
                    else          code <= sda_s ? C_AW_NAK : C_AW_ACK;
                  end else if (rx_mode) begin
                    code <= aa_q ? C_DR_ACK : C_DR_NAK;
                  end else begin
                    code <= sda_s ? C_DT_NAK : C_DT_ACK;
                  end
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  a_r1_no_flag_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    si |-> (status != 8'hF8));

  a_r3_hold_while_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (si && $past(si)) |-> ($stable(status) && $stable(scl_oe) && $stable(sda_oe)));

  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st) == S_BYTE && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));

  a_r9_berr_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (si && status == 8'h00) |-> (!scl_oe && !sda_oe));

  a_r10_arb_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (si && status == 8'h38) |-> (!scl_oe && !sda_oe));

  a_r11_quarter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_WAIT) |-> (qcnt < qtr));

endmodule

// File: tb/i2c_status_master_bench.sv
module i2c_status_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_sta = 0, ctl_sto = 0, ctl_aa = 0, ctl_si = 1;
  logic [2:0] ctl_rate = 3'd6;
  logic dat_wr = 0;
  logic [7:0] dat_wdata = 0, dat_rdata, status;
  logic si, scl_oe, sda_oe, scl_line, sda_line;

  logic slv_ack = 1, slv_send = 0, slv_force = 0, slv_glitch = 0;
  logic [7:0] tx_byte = 0, shin = 0, last_rx = 0;
  logic last_mack = 0, scl_p = 1, sda_p = 1;
  int bitcnt = -1, start_cnt = 0, stop_cnt = 0, rise_cnt = 0, cyc = 0;
  int checks = 0, fails = 0;
  logic slv_pull;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic send_bit(input logic [7:0] b, input int n);
    return b[3'(7 - n)];
  endfunction

  assign slv_pull = slv_force | slv_glitch |
                    (bitcnt == 8 && !slv_send && slv_ack) |
                    (slv_send && bitcnt >= 0 && bitcnt < 8 && !send_bit(tx_byte, bitcnt));
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_pull);

  i2c_status_master u_i2c_status_master (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sta(ctl_sta), .ctl_sto(ctl_sto),
    .ctl_aa(ctl_aa), .ctl_si(ctl_si), .ctl_rate(ctl_rate), .dat_wr(dat_wr),
    .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .status(status), .si(si),
    .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line));

  always @(negedge clk) begin
    if (scl_line && scl_p && sda_p && !sda_line) begin start_cnt++; bitcnt = -1; end
    else if (scl_line && scl_p && !sda_p && sda_line) stop_cnt++;
    if (scl_line && !scl_p) begin
      rise_cnt++;
      if (bitcnt >= 0 && bitcnt < 8) shin = {shin[6:0], sda_line};
      if (bitcnt == 7) last_rx = shin;
      if (bitcnt == 8) last_mack = !sda_line;
    end
    if (!scl_line && scl_p) bitcnt = (bitcnt >= 8) ? 0 : bitcnt + 1;
    scl_p = scl_line;
    sda_p = sda_line;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic sta, input logic sto, input logic aa, input logic clr,
                     input logic wd, input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1; ctl_sta = sta; ctl_sto = sto; ctl_aa = aa; ctl_si = !clr;
    dat_wr = wd; dat_wdata = d;
    @(negedge clk);
    ctl_wr = 0; dat_wr = 0; ctl_si = 1;
  endtask

  task automatic wait_si(input string tag);
    int n = 0;
    while (!si && n < 20000) begin @(negedge clk); n++; end
    if (!si) chk(0, tag, 0, 1);
  endtask

  task automatic step_code(input logic sta, input logic aa, input logic wd, input logic [7:0] d,
                           input logic [7:0] exp, input string tag);
    ctl(sta, 0, aa, 1, wd, d);
    wait_si(tag);
    chk(si && status == exp, tag, status, exp);
  endtask

  task automatic do_stop(input string tag);
    int s0 = stop_cnt, b0 = start_cnt, n = 0;
    ctl(1, 1, 0, 1, 0, 0);
    while (stop_cnt == s0 && n < 20000) begin @(negedge clk); n++; end
    repeat (300) @(negedge clk);
    chk(stop_cnt == s0 + 1, {tag, " R8 stop seen"}, stop_cnt - s0, 1);
    chk(status == 8'hF8 && !si && !scl_oe && !sda_oe, {tag, " R8 idle"}, status, 8'hF8);
    chk(start_cnt == b0, {tag, " R12 stop wins over start"}, start_cnt - b0, 0);
  endtask

  task automatic t_reset;
    chk(status == 8'hF8 && !si && !scl_oe && !sda_oe, "R1 reset", status, 8'hF8);
  endtask

  task automatic t_write_then_read;
    int b0 = start_cnt;
    step_code(1, 0, 0, 0, 8'h08, "R2 start code");
    chk(start_cnt == b0 + 1 && scl_oe, "R2 start on bus", start_cnt - b0, 1);
    repeat (200) @(negedge clk);
    chk(si && status == 8'h08 && scl_oe, "R3 hold while flagged", status, 8'h08);
    slv_ack = 1;
    ctl(0, 0, 0, 1, 1, 8'hA0);
    repeat (60) @(negedge clk);
    ctl(1, 0, 0, 1, 1, 8'h00);
    wait_si("R4 addr");
    chk(status == 8'h18, "R4 write addr ack", status, 8'h18);
    chk(last_rx == 8'hA0, "R13 same-cycle byte sent", last_rx, 8'hA0);
    chk(dat_rdata == 8'hA0, "R12 busy data write ignored", dat_rdata, 8'hA0);
    step_code(0, 0, 1, 8'h5A, 8'h28, "R5 data ack");
    chk(last_rx == 8'h5A, "R5 data on bus", last_rx, 8'h5A);
    slv_ack = 0;
    step_code(0, 0, 1, 8'h33, 8'h30, "R5 data nack");
    slv_ack = 1;
    step_code(1, 0, 0, 0, 8'h10, "R7 repeated start");
    step_code(0, 1, 1, 8'hA1, 8'h40, "R4 read addr ack");
    slv_send = 1; tx_byte = 8'hC3;
    step_code(0, 1, 0, 0, 8'h50, "R6 read ack");
    slv_send = 0;
    chk(dat_rdata == 8'hC3 && last_mack, "R6 byte in and ack out", dat_rdata, 8'hC3);
    slv_send = 1; tx_byte = 8'h3C;
    step_code(0, 0, 0, 0, 8'h58, "R6 read nack");
    slv_send = 0;
    chk(dat_rdata == 8'h3C && !last_mack, "R6 byte in and nack out", dat_rdata, 8'h3C);
    do_stop("R8 after read");
  endtask

  task automatic t_addr_nack;
    slv_ack = 0;
    step_code(1, 0, 0, 0, 8'h08, "R2 start");
    step_code(0, 0, 1, 8'h90, 8'h20, "R4 write addr nack");
    step_code(1, 0, 0, 0, 8'h10, "R7 repeated start");
    step_code(0, 0, 1, 8'h91, 8'h48, "R4 read addr nack");
    slv_ack = 1;
    do_stop("R8 after nack");
  endtask

  task automatic t_bus_error;
    int n = 0;
    step_code(1, 0, 0, 0, 8'h08, "R2 start");
    step_code(0, 0, 1, 8'hA0, 8'h18, "R4 addr");
    ctl(0, 0, 0, 1, 1, 8'hFF);
    while (!(bitcnt == 3 && scl_line) && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    slv_glitch = 1;
    wait_si("R9 bus error");
    chk(status == 8'h00 && !scl_oe && !sda_oe, "R9 bus error code and release", status, 8'h00);
    slv_glitch = 0;
    ctl(0, 0, 0, 1, 0, 0);
    repeat (100) @(negedge clk);
    chk(!si && !scl_oe && !sda_oe, "R9 stays idle after clear", scl_oe, 0);
  endtask

  task automatic t_arb;
    step_code(1, 0, 0, 0, 8'h08, "R2 start");
    step_code(0, 0, 1, 8'hA0, 8'h18, "R4 addr");
    slv_force = 1;
    step_code(0, 0, 1, 8'hFF, 8'h38, "R10 arbitration lost");
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    slv_force = 0;
    ctl(0, 0, 0, 1, 0, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    int r0 = rise_cnt, n = 0;
    while (rise_cnt == r0 && n < 20000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  task automatic t_rate(input logic [2:0] r, input int exp);
    int t1, t2;
    @(negedge clk); ctl_rate = r;
    ctl(0, 0, 0, 0, 0, 0);
    step_code(1, 0, 0, 0, 8'h08, "R11 start");
    ctl(0, 0, 0, 1, 1, 8'hA0);
    wait_rise(t1); wait_rise(t1); wait_rise(t2);
    chk(t2 - t1 == exp, "R11 scl period", t2 - t1, exp);
    wait_si("R11 byte");
    do_stop("R11");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_then_read();
    t_addr_nack();
    t_bus_error();
    t_arb();
    t_rate(3'd0, 256);
    t_rate(3'd4, 960);
    t_rate(3'd7, 60);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule